// File: doc/BRIEF.md
# Display Control Register Decoder

This block takes 32-bit control words from a write-strobe port. The upper byte of each word selects a command, and the lower 24 bits carry that command's arguments. The block keeps a 32-bit status word and a set of display configuration registers: the display origin, the horizontal range and the vertical range. From mode bits held in the status word it derives the horizontal and vertical resolution through two fixed tables. It then computes the visible output width by scaling the horizontal range, which is measured in units of 1/2560 of a line, against the horizontal resolution.

The block records the last accepted word for each of the sixteen command slots. A write that repeats that recorded word is dropped, except for the reset command and the display-origin command, which always act. Every accepted write of the reset, horizontal-range or mode command starts the width divider. The divider is a three-state machine:

- `ST_IDLE`: the result is valid and `width_done` is high.
- `ST_EVAL`: the span is checked and the product is formed. An out-of-range span goes straight back to `ST_IDLE` with the plain resolution as the width. An in-range span moves to `ST_DIVIDE`.
- `ST_DIVIDE`: ten restoring-division steps by 2560, then a return to `ST_IDLE`.

A new start in any state forces `ST_EVAL`. The status read port returns the stored status word with bit 31 replaced by the external line-phase input.

Top module: `disp_ctrl_decoder`

## Requirements
- R1: The command code is `wr_data[31:24]`. A write whose code is 16 or above changes no output, and `width_done` stays high.
- R2: A write equal to the last accepted word of its command slot is ignored. A repeated horizontal-range write therefore leaves `width_done` high. Codes 0 and 5 always act, so a repeated code-0 write restores the reset state.
- R3: Reset and every accepted code-0 write give the following state: status = 0x14802000, all range and origin registers 0, all command slots cleared, resolution 256×240, visible width 256.
- R4: Code 3 copies data bit 0 into status bit 23. Code 4 copies data bits 1:0 into status bits 30:29.
- R5: Code 5 sets display X from data bits 9:0 and display Y from data bits 19:10.
- R6: Code 6 sets horizontal start from data bits 11:0 and horizontal end from bits 23:12. Code 7 sets vertical start from bits 9:0 and vertical end from bits 19:10.
- R7: Code 8 replaces status bits 22:16. Data bit 6 goes to status bit 16, and data bits 5:0 go to status bits 22:17. No other status bit changes.
- R8: The horizontal resolution is looked up with status bits 18:16 in the table 256, 368, 320, 384, 512, 512, 640, 640 (index 0 first). The vertical resolution is looked up with status bits 20:19 in the table 240, 480, 256, 480.
- R9: With span = horizontal end − horizontal start, the visible width equals the horizontal resolution when span ≤ 0 or span ≥ 2560. Otherwise it equals floor(span × resolution / 2560).
- R10: `width_done` falls in the cycle after an accepted code 0, 6 or 8 write. It rises again within 12 cycles, with the new width valid. A further accepted start restarts the computation.
- R11: `status_word` bits 30:0 are the stored status, and bit 31 equals `line_phase`.
- R12: Codes 1, 2 and 9 to 15 are stored in their slots but change no output and do not start the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 32 | Control word: code in 31:24, arguments below |
| line_phase | input | 1 | External line-phase bit for status bit 31 |
| status_word | output | 32 | Status read value |
| disp_x | output | 10 | Display origin X |
| disp_y | output | 10 | Display origin Y |
| h_start | output | 12 | Horizontal range start |
| h_end | output | 12 | Horizontal range end |
| v_start | output | 10 | Vertical range start |
| v_end | output | 10 | Vertical range end |
| h_res | output | 10 | Horizontal resolution |
| v_res | output | 10 | Vertical resolution |
| vis_width | output | 10 | Visible output width |
| width_done | output | 1 | Visible width is valid |

## Verification
The assertions check the following on every cycle:
- the status load after a reset command;
- the bit scatter of the mode command;
- that a dropped duplicate leaves the status untouched;
- that an accepted start leaves `ST_IDLE`;
- that a settled width never exceeds the resolution;
- that the resolution stays inside the table's range.

Only the bench's scenarios can show the rest:
- the exact quotient for each span and resolution pair, including the 0, 1, 2559 and 2560 edges and negative spans;
- the full 128-value mode sweep against both tables;
- that duplicates of code 6 suppress a restart while duplicates of code 0 do not.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int CMD_W      = 8;
    localparam int NUM_SLOTS  = 16;
    localparam int RES_W      = 10;
    localparam int HRANGE_W   = 12;
    localparam int VPOS_W     = 10;
    localparam int SPAN_UNITS = 2560;
    localparam logic [31:0] STATUS_INIT = 32'h1480_2000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_DIVIDE
    } div_state_e;

    function automatic logic [RES_W-1:0] hres_lookup(input logic [2:0] idx);
        logic [RES_W-1:0] r;
        unique case (idx)
            3'd0:    r = 10'd256;
            3'd1:    r = 10'd368;
            3'd2:    r = 10'd320;
            3'd3:    r = 10'd384;
            3'd4,
            3'd5:    r = 10'd512;
            default: r = 10'd640;
        endcase
        return r;
    endfunction

    function automatic logic [RES_W-1:0] vres_lookup(input logic [1:0] idx);
        logic [RES_W-1:0] r;
        unique case (idx)
            2'd0:    r = 10'd240;
            2'd2:    r = 10'd256;
            default: r = 10'd480;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/disp_cmd_regs.sv
module disp_cmd_regs
    import disp_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         status_q,
    output logic [9:0]          dx_q,
    output logic [9:0]          dy_q,
    output logic [HRANGE_W-1:0] hs_q,
    output logic [HRANGE_W-1:0] he_q,
    output logic [VPOS_W-1:0]   vs_q,
    output logic [VPOS_W-1:0]   ve_q,
    output logic                calc_start
);

    localparam int IDX_W = $clog2(NSLOT);

    logic [31:0]      slot_q [NSLOT];
    logic [CMD_W-1:0] code;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             is_dup;
    logic             wr_acc;

    assign code     = wr_data[31:24];
    assign idx      = code[IDX_W-1:0];
    assign in_range = (code < CMD_W'(NSLOT));
    assign is_dup   = (slot_q[idx] == wr_data);
    assign wr_acc   = wr_en && in_range &&
                      ((code == 8'd0) || (code == 8'd5) || !is_dup);

    always_comb begin
        calc_start = 1'b0;
        if (wr_acc) begin
            unique case (code)
                8'd0, 8'd6, 8'd8: calc_start = 1'b1;
                default:          calc_start = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
            status_q <= STATUS_INIT;
            dx_q <= '0;
            dy_q <= '0;
            hs_q <= '0;
            he_q <= '0;
            vs_q <= '0;
            ve_q <= '0;
        end else if (wr_acc) begin
            slot_q[idx] <= wr_data;
            unique case (code)
                8'd0: begin
                    for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
                    status_q <= STATUS_INIT;
                    dx_q <= '0;
                    dy_q <= '0;
                    hs_q <= '0;
                    he_q <= '0;
                    vs_q <= '0;
                    ve_q <= '0;
                end
                8'd3: status_q[23]    <= wr_data[0];
                8'd4: status_q[30:29] <= wr_data[1:0];
                8'd5: begin
                    dx_q <= wr_data[9:0];
                    dy_q <= wr_data[19:10];
                end
                8'd6: begin
                    hs_q <= wr_data[11:0];
                    he_q <= wr_data[23:12];
                end
                8'd7: begin
                    vs_q <= wr_data[9:0];
                    ve_q <= wr_data[19:10];
                end
                8'd8: status_q[22:16] <= {wr_data[5:0], wr_data[6]};
                default: ;
            endcase
        end
    end

    AST_RESET_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'd0) |=> (status_q == STATUS_INIT && hs_q == '0 && he_q == '0)); // R3

    AST_MODE_SCATTER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'd8) |=>
            (status_q[22:16] == {$past(wr_data[5:0]), $past(wr_data[6])})); // R7

    AST_DUP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range && !wr_acc) |=> $stable(status_q)); // R2

    AST_HIGH_CODE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> ($stable(status_q) && $stable(hs_q) && $stable(he_q))); // R1

endmodule

// File: rtl/disp_res_lut.sv
module disp_res_lut
    import disp_pkg::*;
(
    input  logic [31:0]      status_q,
    output logic [RES_W-1:0] hres,
    output logic [RES_W-1:0] vres
);

    assign hres = hres_lookup(status_q[18:16]);
    assign vres = vres_lookup(status_q[20:19]);

    always_comb begin
        AST_HRES_RANGE: assert (hres >= 10'd256 && hres <= 10'd640); // R8
    end

endmodule

// File: rtl/disp_width_div.sv
module disp_width_div
    import disp_pkg::*;
#(
    parameter int DIVISOR = SPAN_UNITS,
    parameter int HW      = HRANGE_W,
    parameter int RW      = RES_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [HW-1:0] hstart,
    input  logic [HW-1:0] hend,
    input  logic [RW-1:0] hres,
    output logic [RW-1:0] width_q,
    output logic          done
);

    localparam int PW    = HW + RW;
    localparam int QW    = RW;
    localparam int STEPW = $clog2(QW);
    localparam logic signed [HW:0] LIMIT   = (HW+1)'(DIVISOR);
    localparam logic        [PW-1:0] DIV_EXT = PW'(DIVISOR);

    div_state_e         state_q, state_d;
    logic [PW-1:0]      rem_q;
    logic [QW-1:0]      quo_q;
    logic [STEPW-1:0]   step_q;
    logic signed [HW:0] span;
    logic               out_of_range;
    logic [PW-1:0]      trial;
    logic               fits;

    assign span         = $signed({1'b0, hend}) - $signed({1'b0, hstart});
    assign out_of_range = (span <= 0) || (span >= LIMIT);
    assign trial        = DIV_EXT << step_q;
    assign fits         = (rem_q >= trial);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_EVAL;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_EVAL:   state_d = out_of_range ? ST_IDLE : ST_DIVIDE;
                ST_DIVIDE: state_d = (step_q == '0) ? ST_IDLE : ST_DIVIDE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= RW'(256);
            rem_q   <= '0;
            quo_q   <= '0;
            step_q  <= '0;
        end else if (!start) begin
            unique case (state_q)
                ST_EVAL: begin
                    if (out_of_range) begin
                        width_q <= hres;
                    end else begin
                        rem_q  <= PW'(span[HW-1:0]) * PW'(hres);
                        quo_q  <= '0;
                        step_q <= STEPW'(QW - 1);
                    end
                end
                ST_DIVIDE: begin
                    if (fits) begin
                        rem_q         <= rem_q - trial;
                        quo_q[step_q] <= 1'b1;
                    end
                    if (step_q == '0) begin
                        width_q <= fits ? (quo_q | RW'(1)) : quo_q;
                    end else begin
                        step_q <= step_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        done = (state_q == ST_IDLE);
    end

    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_EVAL)); // R10

    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (width_q <= hres)); // R9

    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE) |-> (step_q < STEPW'(QW))); // R10

endmodule

// File: rtl/disp_ctrl_decoder.sv
module disp_ctrl_decoder
    import disp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        line_phase,
    output logic [31:0] status_word,
    output logic [9:0]  disp_x,
    output logic [9:0]  disp_y,
    output logic [11:0] h_start,
    output logic [11:0] h_end,
    output logic [9:0]  v_start,
    output logic [9:0]  v_end,
    output logic [9:0]  h_res,
    output logic [9:0]  v_res,
    output logic [9:0]  vis_width,
    output logic        width_done
);

    logic [31:0] status_q;
    logic        calc_start;

    disp_cmd_regs #(.NSLOT(NUM_SLOTS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .status_q   (status_q),
        .dx_q       (disp_x),
        .dy_q       (disp_y),
        .hs_q       (h_start),
        .he_q       (h_end),
        .vs_q       (v_start),
        .ve_q       (v_end),
        .calc_start (calc_start)
    );

    disp_res_lut u_lut (
        .status_q (status_q),
        .hres     (h_res),
        .vres     (v_res)
    );

    disp_width_div #(
        .DIVISOR (SPAN_UNITS),
        .HW      (HRANGE_W),
        .RW      (RES_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (calc_start),
        .hstart  (h_start),
        .hend    (h_end),
        .hres    (h_res),
        .width_q (vis_width),
        .done    (width_done)
    );

    assign status_word = {line_phase, status_q[30:0]};

endmodule

// File: tb/tb_disp_ctrl_decoder.sv
module tb_disp_ctrl_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        line_phase = 1'b0;
    logic [31:0] status_word;
    logic [9:0]  disp_x, disp_y, v_start, v_end, h_res, v_res, vis_width;
    logic [11:0] h_start, h_end;
    logic        width_done;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_stat;

    always #5 clk = ~clk;

    disp_ctrl_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .line_phase(line_phase), .status_word(status_word),
        .disp_x(disp_x), .disp_y(disp_y), .h_start(h_start), .h_end(h_end),
        .v_start(v_start), .v_end(v_end), .h_res(h_res), .v_res(v_res),
        .vis_width(vis_width), .width_done(width_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!width_done && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int hres_ref(input int i);
        int t;
        case (i)
            0: t = 256; 1: t = 368; 2: t = 320; 3: t = 384;
            4, 5: t = 512; default: t = 640;
        endcase
        return t;
    endfunction

    function automatic int vres_ref(input int i);
        int t;
        case (i)
            0: t = 240; 2: t = 256; default: t = 480;
        endcase
        return t;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        exp_stat = 32'h1480_2000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        check("R3 status", status_word, exp_stat);
        check("R3 hres", 32'(h_res), 32'd256);
        check("R3 vres", 32'(v_res), 32'd240);
        check("R3 width", 32'(vis_width), 32'd256);
        check("R3 done", 32'(width_done), 32'd1);
        check("R3 hrange", {8'h0, h_end, h_start}, 32'h0);

        // R11 line phase into bit 31
        line_phase = 1'b1;
        #1;
        check("R11 bit31 high", status_word, exp_stat | 32'h8000_0000);
        line_phase = 1'b0;
        #1;
        check("R11 bit31 low", status_word, exp_stat);

        // R4 blanking and DMA field
        wr(32'h0300_0000); exp_stat[23] = 1'b0;
        check("R4 blank clear", status_word, exp_stat);
        wr(32'h0300_0001); exp_stat[23] = 1'b1;
        check("R4 blank set", status_word, exp_stat);
        for (int k = 0; k < 4; k++) begin
            wr(32'h0400_0000 | 32'(k) | 32'h0000_FF00);
            exp_stat[30:29] = 2'(k);
            check("R4 dma field", status_word, exp_stat);
        end

        // R5 display origin, including a repeated write
        wr(32'h0500_0000 | (32'd321 << 10) | 32'd777);
        check("R5 origin", {12'h0, disp_y, disp_x}, {12'h0, 10'd321, 10'd777});
        wr(32'h0500_0000 | (32'd321 << 10) | 32'd777);
        check("R5 origin repeat", {12'h0, disp_y, disp_x}, {12'h0, 10'd321, 10'd777});

        // R6 vertical range
        wr(32'h0700_0000 | (32'd600 << 10) | 32'd17);
        check("R6 vrange", {12'h0, v_end, v_start}, {12'h0, 10'd600, 10'd17});

        // R7/R8 mode sweep, all 128 argument values with junk above bit 6
        for (int d = 0; d < 128; d++) begin
            logic [6:0] a;
            int hi, vi;
            a = 7'(d);
            wr(32'h0800_0000 | 32'h00AB_CD00 | 32'(d));
            exp_stat[22:16] = {a[5:0], a[6]};
            hi = {a[1], a[0], a[6]};
            vi = {a[3], a[2]};
            check("R7 status scatter", status_word, exp_stat);
            check("R8 hres table", 32'(h_res), 32'(hres_ref(hi)));
            check("R8 vres table", 32'(v_res), 32'(vres_ref(vi)));
            wait_done(n);
        end

        // R9/R10 width sweep over every horizontal resolution
        for (int hi = 0; hi < 8; hi++) begin
            logic [6:0] a;
            a = {1'b0, 1'b0, 1'b0, 1'b0, 3'b000};
            a[6] = hi[0]; a[0] = hi[1]; a[1] = hi[2];
            wr(32'h0800_0000 | 32'(a));
            exp_stat[22:16] = {a[5:0], a[6]};
            wait_done(n);
            for (int k = 0; k < 61; k++) begin
                int span, hs, he, expw;
                case (k)
                    0: span = 0; 1: span = 1; 2: span = 2559; 3: span = 2560; 4: span = -1;
                    default: span = (k - 5) * 47 + 3;
                endcase
                hs = 500;
                he = 500 + span;
                wr(32'h0600_0000 | (32'(he) << 12) | 32'(hs));
                check("R10 done falls", 32'(width_done), 32'd0);
                check("R6 hrange", {8'h0, h_end, h_start}, {8'h0, 12'(he), 12'(hs)});
                wait_done(n);
                if (n > 12) check("R10 latency", 32'(n), 32'd12);
                if (span <= 0 || span >= 2560) expw = hres_ref(hi);
                else expw = (span * hres_ref(hi)) / 2560;
                check("R9 width", 32'(vis_width), 32'(expw));
            end
        end

        // R10 restart while busy: second write wins
        wr(32'h0600_0000 | (32'd1800 << 12) | 32'd100);
        wr(32'h0600_0000 | (32'd1380 << 12) | 32'd100);
        wait_done(n);
        check("R10 restart width", 32'(vis_width), 32'((1280 * hres_ref(7)) / 2560));

        // R2 duplicate horizontal-range write does not restart
        wr(32'h0600_0000 | (32'd1380 << 12) | 32'd100);
        check("R2 dup keeps done", 32'(width_done), 32'd1);

        // R12 stored-only codes
        wr(32'h0900_0001);
        check("R12 code9 done", 32'(width_done), 32'd1);
        check("R12 code9 status", status_word, exp_stat);
        wr(32'h0100_0000);
        wr(32'h02FF_FFFF);
        wr(32'h0F12_3456);
        check("R12 codes status", status_word, exp_stat);
        check("R12 codes hrange", {8'h0, h_end, h_start}, {8'h0, 12'd1380, 12'd100});

        // R1 high codes ignored
        wr(32'h1000_0000);
        wr(32'h2000_0000);
        wr(32'hFF00_0001);
        check("R1 high code status", status_word, exp_stat);
        check("R1 high code done", 32'(width_done), 32'd1);
        check("R1 high code hrange", {8'h0, h_end, h_start}, {8'h0, 12'd1380, 12'd100});

        // R3 code 0, then R2 repeated code 0 still acts
        wr(32'h0000_0000);
        exp_stat = 32'h1480_2000;
        check("R3 cmd0 status", status_word, exp_stat);
        check("R3 cmd0 hrange", {8'h0, h_end, h_start}, 32'h0);
        check("R3 cmd0 origin", {12'h0, disp_y, disp_x}, 32'h0);
        wait_done(n);
        check("R3 cmd0 width", 32'(vis_width), 32'd256);
        wr(32'h0300_0000); exp_stat[23] = 1'b0;
        check("R4 blank after cmd0", status_word, exp_stat);
        wr(32'h0000_0000); exp_stat[23] = 1'b1;
        check("R2 repeated cmd0", status_word, exp_stat);
        wait_done(n);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule